// File: doc/BRIEF.md
# Serial Management Bus Initiator

This block is the master side of a two-wire serial management bus used to reach the configuration registers of up to 32 external transceivers. A user-side request port takes a device address, a register address, a direction and, for writes, a 16-bit data word. The block derives the management clock from the system clock and sends the whole frame: a run of ones as a preamble, the start pair, the opcode, both addresses, the turnaround slot and the data. On a read it releases the data line at the turnaround and samples the bits that the addressed device returns. When the frame is over, it pulses a done strobe and presents the read result.

A strap input is captured while reset is held. It decides whether the block acts as the bus initiator or as a passive listener. As an initiator, the block reads one fixed register on its own right after reset leaves, with no request needed. As a listener, it never drives the bus. The data line is presented as separate output, output-enable and input signals, so the pad tristate buffer is outside this block.

Top module: `mdio_initiator`

## Requirements
- R1: Every frame begins with PRE_LEN (default 32) driven ones. The next two bits are 0 and then 1, and the line is undriven (mdio_oe low) before the frame starts.
- R2: The two opcode bits that follow the start pair are 1,0 for a read (req_write=0) and 0,1 for a write (req_write=1).
- R3: After the opcode come the 5-bit device address and then the 5-bit register address. Both are sent MSB first.
- R4: On a read, mdio_oe falls for the first turnaround bit and stays low through the 16 data bits. Each data bit is sampled from mdio_i on a rising mdc edge and assembled MSB first. The 16-bit result appears on rd_data in the cycle done is high.
- R5: On a write, the turnaround slot is driven as 1 then 0, followed by req_wdata as 16 driven bits, MSB first.
- R6: mdc has a period of 2*CLK_DIV system clocks (the default of 20 gives 2.5 MHz from 100 MHz). mdio_o and mdio_oe change only in the system cycle in which mdc falls.
- R7: busy rises in the cycle after a request is accepted and stays high until done. done is a one-cycle pulse, and busy is low in that same cycle. A request presented while busy is high is ignored and does not alter the frame in flight.
- R8: done is asserted exactly CLK_DIV system cycles after the rising mdc edge that samples the final frame bit. mdio_oe is low from then on.
- R9: With strap_initiator high during reset, the block issues a read of register BOOT_REG (default 1) at device BOOT_PHY (default 0) without any request. That frame ends with done and the read result on rd_data.
- R10: With strap_initiator low during reset, the block is a listener. mdc stays low, mdio_oe is never asserted, busy stays low, and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strap_initiator | input | 1 | Role strap: 1 selects initiator, 0 selects listener |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_phy | input | 5 | Target device address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rd_data | output | 16 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
busy is due one cycle after acceptance, so the bench reads it at the next falling system-clock edge. Each frame bit is captured at the first falling system-clock edge after mdc rises, which is half a system cycle after the design sampled mdio_i. The bench model of the addressed device changes mdio_i at that same moment, a full mdc period before the next sampling edge. done is expected exactly CLK_DIV system cycles after the capture of the last bit, and the bench counts falling system-clock edges from that capture to check it. rd_data and mdio_oe are compared in the cycle of done.

// File: rtl/mdio_pkg.sv
// Shared types for the serial management initiator.
// Assumes frame fields are packed MSB first in the order they go on the wire.
package mdio_pkg;

    localparam int FRAME_BITS = 32;   // start..data, excluding preamble
    localparam int DRIVEN_HEAD = 14;  // start, opcode, two addresses

    typedef struct packed {
        logic        write;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_req_t;

    // Build the 32-bit frame word, first bit to transmit in bit 31.
    function automatic logic [FRAME_BITS-1:0] frame_word(input mdio_req_t r);
        return {2'b01,
                r.write ? 2'b01 : 2'b10,
                r.phy,
                r.regad,
                r.write ? 2'b10 : 2'b00,
                r.write ? r.wdata : 16'h0000};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator.
// Divides clk by 2*CLK_DIV while en is high and holds mdc low otherwise.
// rise_evt/fall_evt flag the system cycle whose edge moves mdc up/down.
// Assumes CLK_DIV >= 2.
module mdio_clkgen #(
    parameter int CLK_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = en && (cnt_q == LAST);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_role.sv
// Role strap capture and post-reset access request.
// Captures the strap while reset is low; an initiator raises boot_pending
// until the sequencer takes the automatic read.
module mdio_role (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic boot_taken,
    output logic is_init,
    output logic boot_pending
);
    // Latch role during reset, clear pending once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_init      <= strap;
            boot_pending <= strap;
        end else if (boot_taken) begin
            boot_pending <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_seq.sv
// Frame sequencer.
// Loads a request when idle, drives one bit per mdc fall (preamble then
// frame word), releases the line on read turnaround/data, samples read
// bits on mdc rise, and pulses done on the fall after the last bit.
// Assumes rise_evt/fall_evt alternate and are single-cycle.
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_req_t   req,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int TOTAL = PRE_LEN + FRAME_BITS;
    localparam int IDX_W = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] IDX_FRAME = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] IDX_REL   = IDX_W'(PRE_LEN + DRIVEN_HEAD);
    localparam logic [IDX_W-1:0] IDX_SAMP  = IDX_W'(PRE_LEN + 17);

    logic [IDX_W-1:0]      idx_q;     // bits already placed on the line
    logic [FRAME_BITS-1:0] frame_q;
    logic                  is_rd_q;
    logic [15:0]           shift_q;

    // Frame state, line drive and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            is_rd_q <= 1'b0;
            rd_data <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    idx_q   <= '0;
                    frame_q <= frame_word(req);
                    is_rd_q <= !req.write;
                end
            end else if (fall_evt) begin
                if (idx_q == IDX_END) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                    if (is_rd_q) rd_data <= shift_q;
                end else begin
                    mdio_oe <= !(is_rd_q && (idx_q >= IDX_REL));
                    if (idx_q < IDX_FRAME) begin
                        mdio_o <= 1'b1;
                    end else begin
                        mdio_o  <= frame_q[FRAME_BITS-1];
                        frame_q <= frame_q << 1;
                    end
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Read data capture on mdc rise during the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (busy && is_rd_q && rise_evt && idx_q >= IDX_SAMP) begin
            shift_q <= {shift_q[14:0], mdio_i};
        end
    end

endmodule

// File: rtl/mdio_initiator.sv
// Serial management bus initiator, top level.
// Selects between the post-reset read and user requests, gates the whole
// engine off in listener role. Pad tristate is external.
module mdio_initiator
    import mdio_pkg::*;
#(
    parameter int         CLK_DIV  = 20,
    parameter int         PRE_LEN  = 32,
    parameter logic [4:0] BOOT_PHY = 5'd0,
    parameter logic [4:0] BOOT_REG = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_initiator,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic      is_init;
    logic      boot_pending;
    logic      start;
    logic      rise_evt;
    logic      fall_evt;
    mdio_req_t sel_req;

    assign start = is_init && !busy && (boot_pending || req_valid);

    // Request source select: post-reset read wins.
    always_comb begin
        if (boot_pending) begin
            sel_req = '{write: 1'b0, phy: BOOT_PHY, regad: BOOT_REG, wdata: 16'h0000};
        end else begin
            sel_req = '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
        end
    end

    mdio_role u_role (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap        (strap_initiator),
        .boot_taken   (start && boot_pending),
        .is_init      (is_init),
        .boot_pending (boot_pending)
    );

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (is_init),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req      (sel_req),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_initiator_chk.sv
// Protocol checker bound to mdio_initiator.
module mdio_initiator_chk (
    input logic clk,
    input logic rst_n,
    input logic is_init,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R6
    line_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R10
    listener_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_init |-> (!mdc && !busy && !mdio_oe));

endmodule

bind mdio_initiator mdio_initiator_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_init (is_init),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_initiator.sv
module tb_mdio_initiator;
    localparam int CLK_DIV = 20;
    localparam int PRE     = 32;
    localparam int NBITS   = PRE + 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mdio_initiator dut (
        .clk(clk), .rst_n(rst_n), .strap_initiator(strap),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_o(input logic wr, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
                wr ? 2'b10 : 2'b00, wr ? wd : 16'h0000};
    endfunction

    function automatic logic [63:0] exp_oe(input logic wr);
        return {32'hFFFF_FFFF, 14'h3FFF, wr ? 18'h3FFFF : 18'h00000};
    endfunction

    // Device response for bit k of a read frame.
    function automatic logic rsp_bit(input int k, input logic [15:0] rsp);
        if (k == PRE + 15) return 1'b0;
        if (k >= PRE + 16 && k < NBITS) return rsp[31 - (k - PRE)];
        return 1'b1;
    endfunction

    // Capture a frame, acting as the addressed device; optionally intrude.
    task automatic capture(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] rsp, input bit intrude);
        logic [63:0] ao = '0, aoe = '0, eo, eoe;
        int cnt = 0, since = 0, guard = 0;
        bit active = 0, got = 0;
        logic prev = mdc;
        mdio_i = 1'b1;
        while (!got && guard < 8000) begin
            @(negedge clk);
            guard++;
            if (intrude && guard == 5) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg;
                req_wdata = ~wd;
            end
            if (intrude && guard == 12) req_valid = 1'b0;
            if (cnt == NBITS) since++;
            if (mdc && !prev && cnt < NBITS && (active || mdio_oe)) begin
                active = 1;
                ao[63 - cnt]  = mdio_o & mdio_oe;
                aoe[63 - cnt] = mdio_oe;
                cnt++;
                mdio_i = rsp_bit(cnt, rsp);
            end
            prev = mdc;
            if (done) got = 1;
        end
        mdio_i = 1'b1;
        eo = exp_o(wr, phy, rg, wd); eoe = exp_oe(wr);
        check("R1 preamble+start", {30'd0, ao[63:30], aoe[63:30]}, {30'd0, eo[63:30], eoe[63:30]});
        check("R2 opcode", {60'd0, ao[29:28], aoe[29:28]}, {60'd0, eo[29:28], eoe[29:28]});
        check("R3 addresses", {44'd0, ao[27:18], aoe[27:18]}, {44'd0, eo[27:18], eoe[27:18]});
        if (wr) check("R5 turnaround+data", {28'd0, ao[17:0], aoe[17:0]}, {28'd0, eo[17:0], eoe[17:0]});
        else    check("R4 released turnaround+data", {28'd0, ao[17:0], aoe[17:0]}, {28'd0, eo[17:0], eoe[17:0]});
        if (!wr) check("R4 rd_data", {48'd0, rd_data}, {48'd0, rsp});
        check("R8 done delay", 64'(since), 64'(CLK_DIV));
        check("R7 done with busy low", {62'd0, done, busy}, {62'd0, 1'b1, 1'b0});
        check("R8 line released", {63'd0, mdio_oe}, 64'd0);
        if (intrude) check("R7 ignored request", ao, eo & eoe);
        @(negedge clk);
        check("R7 done one pulse", {63'd0, done}, 64'd0);
    endtask

    task automatic txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] rsp, input bit intrude);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 busy after accept", {63'd0, busy}, 64'd1);
        capture(wr, phy, rg, wd, rsp, intrude);
    endtask

    task automatic run_all();
        // Initiator reset and post-reset read.
        strap = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset idle", {62'd0, mdio_oe, busy}, 64'd0);
        rst_n = 1'b1;
        capture(1'b0, 5'd0, 5'd1, 16'h0, 16'hA5C3, 0);   // R9
        check("R9 boot read result", {48'd0, rd_data}, 64'hA5C3);

        // Clock period.
        begin
            int n = 0, rises = 0;
            logic p = mdc;
            while (rises < 2 && n < 200) begin
                @(negedge clk);
                if (rises == 1) n++;
                if (mdc && !p) rises++;
                p = mdc;
            end
            check("R6 mdc period", 64'(n), 64'(2 * CLK_DIV));
        end

        // Directed corners.
        txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 0);
        txn(1'b0, 5'd0, 5'd0, 16'h0, 16'h0000, 0);
        txn(1'b0, 5'd31, 5'd0, 16'h0, 16'hFFFF, 0);
        txn(1'b1, 5'd10, 5'd21, 16'h8001, 16'h0, 1);
        txn(1'b0, 5'd5, 5'd17, 16'h0, 16'h1234, 1);

        // Random mix.
        void'($urandom(32'd2024));
        for (int i = 0; i < 14; i++) begin
            txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 0);
        end

        // Listener role.
        rst_n = 1'b0; strap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd3; req_reg = 5'd4; req_wdata = 16'h5555;
        begin
            bit seen = 0;
            for (int c = 0; c < 3000; c++) begin
                @(negedge clk);
                if (mdc || mdio_oe || busy || done) seen = 1;
            end
            check("R10 listener stays silent", {63'd0, seen}, 64'd0);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule